// File: doc/BRIEF.md
# Grouped Common-Line Scan Sequencer

This block walks the common rows of a 184-row multi-line-addressed panel. Rows are driven four at a time, so the scan moves in 46 groups of four rows. Each group is held for one line period, and one line period is two display clock cycles. On every clock the block reports which group is selected. It also gives a strobe on the last clock of each line period and a pulse on the first clock of each frame.

Two registers set the visible window. The first names the group where the window begins. It is written in two-row units, and because groups are four rows wide its lowest bit does not move the scan. The second gives the window height in groups. Both registers check each write against its limit and drop any write that is out of range. A direction input chooses whether groups are visited in rising or falling order.

When the window runs past the last group it continues at group 0, and when a falling scan passes group 0 it continues at group 45. A new start, height or direction is held back until the current frame ends. Rewriting the start once per frame therefore scrolls the picture without tearing it.

Top module: `mls_com_scan`

## Requirements
- R1: While reset is held and on the first clock after it, `group_idx` is 0, `frame_start` is 1 and `line_strobe` is 0. Out of reset the scan runs forward over all 46 groups, so a frame lasts 92 clocks.
- R2: `line_strobe` is high on the second clock of each two-clock line period and low on the first clock.
- R3: In forward mode, at position p of a frame (p counted from 0), `group_idx` equals (S + p) mod 46, where S is the start group. The scan therefore wraps from group 45 to group 0.
- R4: In reverse mode (`dir_rev` = 1 when latched), `group_idx` equals (S − p) mod 46, so the scan wraps from group 0 to group 45.
- R5: `frame_start` is high only on the first clock of line position 0 of each frame. A frame is exactly 2·(k+1) clocks long, where k is the active height value.
- R6: A height value k from 0 to 45 selects k+1 groups, that is 4(k+1) rows. A height write of 46 or more is ignored and the previous height is kept.
- R7: A start value s from 0 to 91 selects start group floor(s/2), that is row 4·floor(s/2). A start write of 92 or more is ignored.
- R8: Start, height and `dir_rev` take effect only at the next frame boundary. A write made during a frame does not change the frame that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_we | input | 1 | Write strobe for the start register |
| start_val | input | 7 | Start value in two-row units (legal range 0 to 91) |
| lines_we | input | 1 | Write strobe for the height register |
| lines_val | input | 6 | Height value k; the window is k+1 groups (legal range 0 to 45) |
| dir_rev | input | 1 | Scan order: 1 is falling, 0 is rising. Sampled at each frame boundary |
| group_idx | output | 6 | Index of the selected four-row group |
| frame_start | output | 1 | High on the first clock of each frame |
| line_strobe | output | 1 | High on the last clock of each line period |

## Verification
A stepping error in the group register, such as a missed wrap or a wrong direction, shows on `group_idx` at the line strobe where it happens. It also carries into every group that follows in that frame. A corrupted position counter or a wrong height changes the spacing of `frame_start` within a single frame. A pending register that takes a write too early, or takes an illegal one, shows only at the next frame boundary, in the first group and in the length of the frame. For that reason the bench compares every output on every clock against an independent position-based model.

// File: rtl/mls_scan_pkg.sv
package mls_scan_pkg;

   typedef enum logic {
      DIR_FWD = 1'b0,
      DIR_REV = 1'b1
   } scan_dir_e;

   // next group index around a ring of n groups
   function automatic logic [31:0] grp_step(input logic [31:0] g,
                                            input scan_dir_e   d,
                                            input logic [31:0] n);
      if (d == DIR_FWD) return (g == n - 1) ? 32'd0 : g + 32'd1;
      else              return (g == 32'd0) ? n - 1 : g - 32'd1;
   endfunction

endpackage

// File: rtl/mls_line_timer.sv
module mls_line_timer #(
   parameter int unsigned LINE_CLKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic line_first,
   output logic line_last
);
   localparam int unsigned PH_W = (LINE_CLKS > 1) ? $clog2(LINE_CLKS) : 1;
   localparam bit          POW2 = ((LINE_CLKS & (LINE_CLKS - 1)) == 0);

   logic [PH_W-1:0] ph_q;

   generate
      if (LINE_CLKS < 2) begin : g_bad_clks
         $error("mls_line_timer: LINE_CLKS must be at least 2");
      end
      if (POW2) begin : g_wrap_free
         always_ff @(posedge clk) begin
            if (!rst_n) ph_q <= '0;
            else        ph_q <= ph_q + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_ff @(posedge clk) begin
            if (!rst_n)                            ph_q <= '0;
            else if (ph_q == PH_W'(LINE_CLKS - 1)) ph_q <= '0;
            else                                   ph_q <= ph_q + 1'b1;
         end
      end
   endgenerate

   assign line_first = (ph_q == '0);
   assign line_last  = (ph_q == PH_W'(LINE_CLKS - 1));
endmodule

// File: rtl/mls_scan_cfg.sv
module mls_scan_cfg
   import mls_scan_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 46,
   parameter int unsigned GW         = 6,
   parameter int unsigned START_W    = 7,
   parameter int unsigned LINES_W    = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_we,
   input  logic [START_W-1:0] start_val,
   input  logic               lines_we,
   input  logic [LINES_W-1:0] lines_val,
   input  logic               dir_rev,
   input  logic               frame_end,
   output logic [GW-1:0]      next_start_grp,
   output logic [LINES_W-1:0] act_lines,
   output scan_dir_e          act_dir
);
   localparam int unsigned START_LIMIT = 2 * NUM_GROUPS;
   localparam int unsigned LINES_RST   = NUM_GROUPS - 1;

   logic [START_W-1:0] pend_start_q;
   logic [LINES_W-1:0] pend_lines_q;
   logic [LINES_W-1:0] act_lines_q;
   scan_dir_e          act_dir_q;
   logic               start_ok, lines_ok;

   generate
      if (START_W < $clog2(START_LIMIT)) begin : g_bad_start_w
         $error("mls_scan_cfg: START_W too narrow for the start range");
      end
      if (LINES_W < $clog2(NUM_GROUPS)) begin : g_bad_lines_w
         $error("mls_scan_cfg: LINES_W too narrow for the height range");
      end
   endgenerate

   assign start_ok = (32'(start_val) < START_LIMIT);
   assign lines_ok = (32'(lines_val) < NUM_GROUPS);

   // pending copies take legal writes at any time
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_start_q <= '0;
         pend_lines_q <= LINES_W'(LINES_RST);
      end else begin
         if (start_we && start_ok) pend_start_q <= start_val;
         if (lines_we && lines_ok) pend_lines_q <= lines_val;
      end
   end

   // active copies only move at a frame boundary
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_lines_q <= LINES_W'(LINES_RST);
         act_dir_q   <= DIR_FWD;
      end else if (frame_end) begin
         act_lines_q <= pend_lines_q;
         act_dir_q   <= dir_rev ? DIR_REV : DIR_FWD;
      end
   end

   assign next_start_grp = GW'(pend_start_q[START_W-1:1]);
   assign act_lines      = act_lines_q;
   assign act_dir        = act_dir_q;
endmodule

// File: rtl/mls_group_walker.sv
module mls_group_walker
   import mls_scan_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 46,
   parameter int unsigned GW         = 6,
   parameter int unsigned LINES_W    = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_first,
   input  logic               line_last,
   input  logic [LINES_W-1:0] act_lines,
   input  scan_dir_e          act_dir,
   input  logic [GW-1:0]      next_start_grp,
   output logic [GW-1:0]      grp_idx,
   output logic               frame_end,
   output logic               frame_first
);
   logic [LINES_W-1:0] pos_q;
   logic [GW-1:0]      cur_q;
   logic               last_pos;

   assign last_pos  = (pos_q == act_lines);
   assign frame_end = line_last && last_pos;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
         cur_q <= '0;
      end else if (frame_end) begin
         pos_q <= '0;
         cur_q <= next_start_grp;
      end else if (line_last) begin
         pos_q <= pos_q + 1'b1;
         cur_q <= GW'(grp_step(32'(cur_q), act_dir, NUM_GROUPS));
      end
   end

   assign grp_idx     = cur_q;
   assign frame_first = line_first && (pos_q == '0);
endmodule

// File: rtl/mls_com_scan.sv
module mls_com_scan #(
   parameter int unsigned NUM_COM     = 184,
   parameter int unsigned GROUP_LINES = 4,
   parameter int unsigned LINE_CLKS   = 2,
   parameter int unsigned NUM_GROUPS  = NUM_COM / GROUP_LINES,
   parameter int unsigned GW          = $clog2(NUM_GROUPS),
   parameter int unsigned START_W     = $clog2(2 * NUM_GROUPS),
   parameter int unsigned LINES_W     = $clog2(NUM_GROUPS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_we,
   input  logic [START_W-1:0] start_val,
   input  logic               lines_we,
   input  logic [LINES_W-1:0] lines_val,
   input  logic               dir_rev,
   output logic [GW-1:0]      group_idx,
   output logic               frame_start,
   output logic               line_strobe
);
   import mls_scan_pkg::*;

   generate
      if (NUM_COM % GROUP_LINES != 0) begin : g_bad_grouping
         $error("mls_com_scan: NUM_COM must be a multiple of GROUP_LINES");
      end
      if (NUM_GROUPS != NUM_COM / GROUP_LINES || NUM_GROUPS < 2) begin : g_bad_groups
         $error("mls_com_scan: NUM_GROUPS inconsistent with NUM_COM");
      end
   endgenerate

   logic          line_first, line_last, frame_end;
   logic [GW-1:0]      next_start_grp;
   logic [LINES_W-1:0] act_lines;
   scan_dir_e          act_dir;

   mls_line_timer #(.LINE_CLKS(LINE_CLKS)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_first (line_first),
      .line_last  (line_last)
   );

   mls_scan_cfg #(
      .NUM_GROUPS (NUM_GROUPS),
      .GW         (GW),
      .START_W    (START_W),
      .LINES_W    (LINES_W)
   ) u_cfg (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_we       (start_we),
      .start_val      (start_val),
      .lines_we       (lines_we),
      .lines_val      (lines_val),
      .dir_rev        (dir_rev),
      .frame_end      (frame_end),
      .next_start_grp (next_start_grp),
      .act_lines      (act_lines),
      .act_dir        (act_dir)
   );

   mls_group_walker #(
      .NUM_GROUPS (NUM_GROUPS),
      .GW         (GW),
      .LINES_W    (LINES_W)
   ) u_walk (
      .clk            (clk),
      .rst_n          (rst_n),
      .line_first     (line_first),
      .line_last      (line_last),
      .act_lines      (act_lines),
      .act_dir        (act_dir),
      .next_start_grp (next_start_grp),
      .grp_idx        (group_idx),
      .frame_end      (frame_end),
      .frame_first    (frame_start)
   );

   assign line_strobe = line_last;
endmodule

// File: rtl/mls_com_scan_chk.sv
module mls_com_scan_chk #(
   parameter int unsigned NUM_GROUPS = 46,
   parameter int unsigned GW         = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic [GW-1:0] group_idx,
   input logic          frame_start,
   input logic          line_strobe
);
   logic [GW-1:0] grp_up, grp_dn;
   assign grp_up = (32'(group_idx) == NUM_GROUPS - 1) ? '0 : group_idx + 1'b1;
   assign grp_dn = (group_idx == '0) ? GW'(NUM_GROUPS - 1) : group_idx - 1'b1;

   assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      line_strobe |=> !line_strobe);

   assert_frame_first_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> !line_strobe);

   assert_group_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(group_idx) < NUM_GROUPS);

   assert_group_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !line_strobe |=> $stable(group_idx));

   // R4 and R3: one ring step per line, except a reload at a frame start
   assert_group_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      line_strobe |=> (frame_start || group_idx == $past(grp_up) || group_idx == $past(grp_dn)));
endmodule

bind mls_com_scan mls_com_scan_chk #(
   .NUM_GROUPS (NUM_GROUPS),
   .GW         (GW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .group_idx   (group_idx),
   .frame_start (frame_start),
   .line_strobe (line_strobe)
);

// File: tb/mls_com_scan_test.sv
module mls_com_scan_test;
   localparam int NG = 46;
   localparam int LC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_we = 1'b0;
   logic [6:0] start_val = '0;
   logic       lines_we = 1'b0;
   logic [5:0] lines_val = '0;
   logic       dir_rev = 1'b0;
   logic [5:0] group_idx;
   logic       frame_start, line_strobe;

   always #10 clk = ~clk;

   mls_com_scan uut (
      .clk (clk), .rst_n (rst_n),
      .start_we (start_we), .start_val (start_val),
      .lines_we (lines_we), .lines_val (lines_val),
      .dir_rev (dir_rev),
      .group_idx (group_idx), .frame_start (frame_start), .line_strobe (line_strobe)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // behavioural model: phase, position in frame, active and pending settings
   int m_ph, m_pos, m_sg, m_nl, m_dir, p_start, p_lines;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_pos = 0; m_sg = 0; m_nl = NG - 1; m_dir = 0;
         p_start = 0; p_lines = NG - 1;
      end else begin
         if (m_ph == LC - 1) begin
            if (m_pos == m_nl) begin
               m_sg = p_start / 2; m_nl = p_lines; m_dir = int'(dir_rev); m_pos = 0;
            end else m_pos++;
         end
         m_ph = (m_ph + 1) % LC;
         if (start_we && int'(start_val) < 2 * NG) p_start = int'(start_val);
         if (lines_we && int'(lines_val) < NG) p_lines = int'(lines_val);
      end
   end

   function automatic int exp_group();
      if (m_dir != 0) return (((m_sg - m_pos) % NG) + NG) % NG;
      return (m_sg + m_pos) % NG;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (m_dir != 0) check("R4 reverse group", int'(group_idx), exp_group());
         else            check("R3 forward group", int'(group_idx), exp_group());
         check("R2 line strobe", int'(line_strobe), int'(m_ph == LC - 1));
         check("R5 frame start", int'(frame_start), int'(m_ph == 0 && m_pos == 0));
      end
   end

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      summary();
      $finish;
   end

   task automatic wait_fs();
      do @(negedge clk); while (!frame_start);
   endtask

   task automatic measure_frame(output int n);
      wait_fs();
      n = 0;
      do begin @(negedge clk); n++; end while (!frame_start);
   endtask

   task automatic wr_start(input int v);
      @(negedge clk); start_we = 1'b1; start_val = 7'(v);
      @(negedge clk); start_we = 1'b0;
   endtask

   task automatic wr_lines(input int v);
      @(negedge clk); lines_we = 1'b1; lines_val = 6'(v);
      @(negedge clk); lines_we = 1'b0;
   endtask

   initial begin
      int fl;
      int g;
      repeat (3) @(negedge clk);
      check("R1 group in reset", int'(group_idx), 0);
      rst_n = 1'b1;
      check("R1 group after reset", int'(group_idx), 0);
      check("R1 frame start after reset", int'(frame_start), 1);
      check("R1 strobe after reset", int'(line_strobe), 0);
      measure_frame(fl);
      check("R1 reset frame length", fl, 92);

      // R8: height write during a frame leaves that frame alone
      wait_fs();
      lines_we = 1'b1; lines_val = 6'd9;
      fl = 0;
      do begin @(negedge clk); lines_we = 1'b0; fl++; end while (!frame_start);
      check("R8 running frame keeps height", fl, 92);
      measure_frame(fl);
      check("R6 height 9 gives 20 clocks", fl, 20);

      // R6: illegal heights ignored
      wait_fs(); wr_lines(46);
      wait_fs(); wr_lines(63);
      measure_frame(fl);
      check("R6 illegal height ignored", fl, 20);

      // R7 and R3: start 90 is group 45, then wraps to 0
      wait_fs(); wr_start(90);
      wait_fs();
      check("R7 start 90 group", int'(group_idx), 45);
      repeat (LC) @(negedge clk);
      check("R3 wrap 45 to 0", int'(group_idx), 0);

      // R8: start write mid-frame does not disturb stepping
      g = int'(group_idx);
      wr_start(10);
      check("R8 stepping unchanged after start write", int'(group_idx), (g + 1) % NG);
      wait_fs();
      check("R7 start 10 group", int'(group_idx), 5);

      // R7: odd start, then illegal starts ignored
      wait_fs(); wr_start(91);
      wait_fs();
      check("R7 start 91 group", int'(group_idx), 45);
      wr_start(92); wr_start(127);
      wait_fs();
      check("R7 illegal start ignored", int'(group_idx), 45);

      // R4: reverse from group 2 wraps below zero
      wait_fs(); dir_rev = 1'b1; wr_start(4);
      wait_fs();
      check("R4 reverse start", int'(group_idx), 2);
      repeat (LC) @(negedge clk); check("R4 reverse step", int'(group_idx), 1);
      repeat (LC) @(negedge clk); check("R4 reverse step", int'(group_idx), 0);
      repeat (LC) @(negedge clk); check("R4 reverse wrap", int'(group_idx), 45);

      // R8: direction change waits for the boundary
      g = int'(group_idx);
      dir_rev = 1'b0;
      repeat (LC) @(negedge clk);
      check("R8 direction held in frame", int'(group_idx), (g + NG - 1) % NG);

      // R6: full height again
      wait_fs(); wr_lines(45);
      measure_frame(fl);
      check("R6 height 45 gives 92 clocks", fl, 92);
      wait_fs();
      check("R3 forward restored at boundary", int'(group_idx), 2);

      summary();
      $finish;
   end
endmodule